// File: doc/BRIEF.md
# Prescaled Seconds Timer with Alarm

The block is a memory-mapped real-time timer. A slow-clock enable strobe (`slow_tick`, one pulse per slow-clock period, synchronous to the bus clock) drives a 16-bit prescaler. Each time the prescaler has counted its programmed number of strobes, it wraps and a 32-bit up-counter advances by one. Programming the prescaler to the slow-clock frequency therefore gives one count per second. Software cannot load the counter. It can only restart it, which returns the counter and the prescaler to zero. Software normally keeps a base-time offset elsewhere and adds it to the count.

Four word registers sit on a simple read/write strobe bus. The byte address is decoded on bits [3:2]:

- Control (0x0) holds the prescaler value, the two event enables and the restart command.
- Alarm (0x4) holds the alarm compare value.
- Count (0x8) is read-only.
- Events (0xC) holds the sticky flags and clears when read.

Two events are flagged: the counter reaching the alarm value, and every counter increment. The single level interrupt is high while a flagged event is also enabled.

The restart sequencing is a two-state machine:

- `ST_RUN` counts normally. A control write with the restart bit moves it to `ST_CLEAR`.
- `ST_CLEAR` holds the counter still. On the next slow-clock strobe it zeroes the counter and the prescaler and returns to `ST_RUN`, unless a new restart write arrives in that same cycle, in which case it stays in `ST_CLEAR`.

Top module: `rtt_timer`

## Requirements
- R1: Register map. Reads at byte offset 0x0 return the control word: prescaler in bits [15:0], alarm enable in bit 16, increment enable in bit 17, restart (write-only) in bit 18. Reads at 0x4 return the alarm value and reads at 0x8 return the counter. Reads at 0xC return the event flags: alarm flag in bit 0, increment flag in bit 1. After reset the control word is 0x00008000.
- R2: When the prescaler value P is nonzero, the counter increments on the P-th slow-clock strobe since the last wrap or restart.
- R3: Writes to offsets 0x8 and 0xC are ignored. The counter changes only by incrementing or restarting.
- R4: A control write with bit 18 set leaves bit 18 reading 0 and freezes counting. The next strobe then clears the counter and prescaler to 0.
- R5: The alarm register resets to 0xFFFFFFFF. Events bit 0 is set on the increment that makes the counter equal to the alarm value, and never while the alarm holds 0xFFFFFFFF.
- R6: Events bit 1 is set on every counter increment.
- R7: A read of offset 0xC clears both flags. An event arising in the same cycle as that read stays set.
- R8: `irq` is high exactly when (events[1:0] AND control[17:16]) is nonzero.
- R9: A prescaler value of 0 counts 65536 strobes per increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the events register when it addresses 0xC) |
| bus_addr | input | 4 | Byte address; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after the following corner cases:

- **Event coinciding with a flag read.** A design that lets the read-clear win would lose the increment flag.
- **Restart write coinciding with a strobe.** A design that cleared immediately, or counted in `ST_CLEAR`, would show a count off by one.
- **Prescaler value 0.** A design that took 0 literally would advance every strobe or never.
- **All-ones alarm.** A design that compared it like any other value would raise a spurious alarm flag and interrupt.

Random strobes, register reads and writes with small prescaler values are checked against a bench model, including the interrupt on every cycle.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
    localparam int DATA_W = 32;
    localparam int PRE_W  = 16;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_ALARM = 2'd1;
    localparam logic [1:0] SEL_COUNT = 2'd2;
    localparam logic [1:0] SEL_EVENT = 2'd3;

    localparam int BIT_ALM_EN  = 16;
    localparam int BIT_INC_EN  = 17;
    localparam int BIT_RESTART = 18;

    localparam int EV_ALARM = 0;
    localparam int EV_INC   = 1;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_CLEAR = 1'b1
    } rtt_state_e;
endpackage

// File: rtl/rtt_prescaler.sv
module rtt_prescaler #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [PRE_W-1:0] presc_i,
    output logic             wrap_o
);
    localparam int LIM_W = PRE_W + 1;

    logic [PRE_W-1:0] pre_q;
    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] pre_inc;

    always_comb begin
        limit   = (presc_i == '0) ? (LIM_W'(1) << PRE_W) : {1'b0, presc_i};
        pre_inc = {1'b0, pre_q} + LIM_W'(1);
        wrap_o  = tick_i && run_i && (pre_inc >= limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr_i) begin
            pre_q <= '0;
        end else if (tick_i && run_i) begin
            pre_q <= wrap_o ? '0 : pre_inc[PRE_W-1:0];
        end
    end

    assert_pre_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pre_q == '0));

    assert_pre_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/rtt_count_ctrl.sv
module rtt_count_ctrl
    import rtt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wrap_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] alarm_i,
    output logic             run_o,
    output logic             clr_pre_o,
    output logic [CNT_W-1:0] count_o,
    output logic             inc_evt_o,
    output logic             alm_evt_o
);
    rtt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (restart_i) state_d = ST_CLEAR;
            ST_CLEAR: if (tick_i && !restart_i) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        run_o     = (state_q == ST_RUN);
        clr_pre_o = (state_q == ST_CLEAR) && tick_i;
        count_nxt = count_q + CNT_W'(1);
        inc_evt_o = wrap_i;
        alm_evt_o = wrap_i && (alarm_i != '1) && (count_nxt == alarm_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         count_q <= '0;
        else if (clr_pre_o) count_q <= '0;
        else if (wrap_i)    count_q <= count_nxt;
    end

    assign count_o = count_q;

    assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CLEAR) && tick_i) |=> (count_q == '0));

    assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(count_q));

    assert_clear_no_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |-> !wrap_i);

    assert_alarm_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alm_evt_o |=> (count_q == $past(alarm_i)));
endmodule

// File: rtl/rtt_events.sv
module rtt_events (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] evt_i,
    input  logic       rd_clr_i,
    input  logic [1:0] en_i,
    output logic [1:0] flags_o,
    output logic       irq_o
);
    logic [1:0] flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (rd_clr_i ? 2'b00 : flag_q) | evt_i;
    end

    assign flags_o = flag_q;
    assign irq_o   = |(flag_q & en_i);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && (evt_i == 2'b00)) |=> (flag_q == 2'b00 && !irq_o));

    assert_pending_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && evt_i[1]) |=> flag_q[1]);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr_i && flag_q[1]) |=> flag_q[1]);
endmodule

// File: rtl/rtt_timer.sv
module rtt_timer
    import rtt_pkg::*;
#(
    parameter int          CNT_W       = 32,
    parameter int          ADDR_W      = 4,
    parameter logic [15:0] RESET_PRESC = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [1:0]       sel;
    logic [PRE_W-1:0] presc_q;
    logic             alm_en_q, inc_en_q;
    logic [CNT_W-1:0] alarm_q;
    logic             restart_wr, rd_events;
    logic             wrap, run, clr_pre, inc_evt, alm_evt;
    logic [CNT_W-1:0] count;
    logic [1:0]       flags;

    assign sel        = bus_addr[3:2];
    assign restart_wr = bus_wr && (sel == SEL_CTRL) && bus_wdata[BIT_RESTART];
    assign rd_events  = bus_rd && (sel == SEL_EVENT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q  <= RESET_PRESC;
            alm_en_q <= 1'b0;
            inc_en_q <= 1'b0;
            alarm_q  <= '1;
        end else if (bus_wr) begin
            unique case (sel)
                SEL_CTRL: begin
                    presc_q  <= bus_wdata[PRE_W-1:0];
                    alm_en_q <= bus_wdata[BIT_ALM_EN];
                    inc_en_q <= bus_wdata[BIT_INC_EN];
                end
                SEL_ALARM: alarm_q <= bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    rtt_prescaler #(.PRE_W(PRE_W)) i_pre (
        .clk(clk), .rst_n(rst_n), .tick_i(slow_tick), .run_i(run),
        .clr_i(clr_pre), .presc_i(presc_q), .wrap_o(wrap)
    );

    rtt_count_ctrl #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(slow_tick), .wrap_i(wrap),
        .restart_i(restart_wr), .alarm_i(alarm_q), .run_o(run),
        .clr_pre_o(clr_pre), .count_o(count), .inc_evt_o(inc_evt),
        .alm_evt_o(alm_evt)
    );

    rtt_events i_evt (
        .clk(clk), .rst_n(rst_n), .evt_i({inc_evt, alm_evt}),
        .rd_clr_i(rd_events), .en_i({inc_en_q, alm_en_q}),
        .flags_o(flags), .irq_o(irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CTRL: begin
                bus_rdata[PRE_W-1:0]  = presc_q;
                bus_rdata[BIT_ALM_EN] = alm_en_q;
                bus_rdata[BIT_INC_EN] = inc_en_q;
            end
            SEL_ALARM: bus_rdata[CNT_W-1:0] = alarm_q;
            SEL_COUNT: bus_rdata[CNT_W-1:0] = count;
            SEL_EVENT: bus_rdata[1:0]       = flags;
            default: ;
        endcase
    end

    assert_no_alarm_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((alarm_q == '1) && !flags[EV_ALARM]) |=> !flags[EV_ALARM]);

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_en_q && !inc_en_q) |-> !irq);

    assert_restart_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_CTRL) |-> !bus_rdata[BIT_RESTART]);
endmodule

// File: tb/test_rtt_timer.sv
module test_rtt_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    int unsigned m_pre, m_presc;
    logic [31:0] m_cnt, m_alarm;
    bit          m_pend, m_aen, m_ien;
    logic [1:0]  m_flags;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtt_timer i_rtt_timer (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a[3:2])
            2'd0:    return {13'd0, 1'b0, m_ien, m_aen, m_presc[15:0]};
            2'd1:    return m_alarm;
            2'd2:    return m_cnt;
            default: return {30'd0, m_flags};
        endcase
    endfunction

    function automatic bit model_irq();
        return |(m_flags & {m_ien, m_aen});
    endfunction

    task automatic model_reset();
        m_pre = 0; m_presc = 32'h8000; m_cnt = '0; m_alarm = '1;
        m_pend = 0; m_aen = 0; m_ien = 0; m_flags = '0;
    endtask

    task automatic model_step(input bit tk, input bit wr, input logic [3:0] a,
                              input logic [31:0] wd, input bit rd);
        logic [1:0]  ev = '0;
        int unsigned lim;
        if (tk) begin
            if (m_pend) begin
                m_pre = 0; m_cnt = '0; m_pend = 0;
            end else begin
                lim = (m_presc == 0) ? 65536 : m_presc;
                if (m_pre + 1 >= lim) begin
                    m_pre = 0;
                    m_cnt = m_cnt + 1;
                    ev[1] = 1'b1;
                    if (m_alarm != 32'hFFFF_FFFF && m_cnt == m_alarm) ev[0] = 1'b1;
                end else begin
                    m_pre = m_pre + 1;
                end
            end
        end
        m_flags = ((rd && a[3:2] == 2'd3) ? 2'b00 : m_flags) | ev;
        if (wr) begin
            if (a[3:2] == 2'd0) begin
                m_presc = wd[15:0]; m_aen = wd[16]; m_ien = wd[17];
                if (wd[18]) m_pend = 1;
            end else if (a[3:2] == 2'd1) begin
                m_alarm = wd;
            end
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit tk, input bit wr, input logic [3:0] a,
                       input logic [31:0] wd, input bit rd, input string tag);
        @(negedge clk);
        slow_tick = tk; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        #1;
        if (rd) check(tag, bus_rdata, model_read(a));
        check("R8 irq", {31'd0, irq}, {31'd0, model_irq()});
        @(posedge clk);
        model_step(tk, wr, a, wd, rd);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 4'h0, 0, 0, "");
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        cyc(0, 0, a, 0, 1, tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(0, 1, a, d, 0, "");
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 / R5 reset values
        rd(4'h0, "R1 reset control");
        rd(4'h4, "R5 reset alarm");
        rd(4'h8, "R1 reset count");
        rd(4'hC, "R7 reset events");

        // R4 restart with prescaler 3, both enables
        wr(4'h0, 32'h0007_0003);
        rd(4'h0, "R4 restart reads 0");
        ticks(1);                          // clears
        ticks(2);
        rd(4'h8, "R2 before third strobe");
        ticks(1);
        rd(4'h8, "R2 after third strobe");

        // R3 writes to count/events ignored
        wr(4'h8, 32'h1234_5678);
        wr(4'hC, 32'h3);
        rd(4'h8, "R3 count not writable");

        // R6 / R7 read clears
        rd(4'hC, "R6 inc flag");
        rd(4'hC, "R7 cleared");

        // R5 alarm at count+2
        wr(4'h4, m_cnt + 2);
        ticks(6);
        rd(4'hC, "R5 alarm flag");
        rd(4'hC, "R7 cleared again");

        // R7 event in same cycle as read
        ticks(2);
        cyc(1, 0, 4'hC, 0, 1, "R7 read with event");
        rd(4'hC, "R7 pending kept");

        // R5 all-ones alarm: no alarm flag
        wr(4'h4, 32'hFFFF_FFFF);
        ticks(9);
        rd(4'hC, "R5 disabled alarm");

        // R4 restart coinciding with strobe
        cyc(1, 1, 4'h0, 32'h0004_0002, 0, "");
        ticks(1);
        rd(4'h8, "R4 cleared on next strobe");
        ticks(2);
        rd(4'h8, "R4 counting resumes");

        // R9 prescaler 0
        wr(4'h0, 32'h0006_0000);
        ticks(1);
        ticks(65535);
        rd(4'h8, "R9 one short of 65536");
        ticks(1);
        rd(4'h8, "R9 at 65536");

        // random mix
        wr(4'h0, 32'h0007_0002);
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom_range(0, 99);
            bit tk = ($urandom_range(0, 2) != 0);
            if (r < 3) begin
                logic [31:0] d = {13'd0, ($urandom_range(0, 7) == 0),
                                  1'($urandom), 1'($urandom),
                                  16'($urandom_range(1, 4))};
                cyc(tk, 1, 4'h0, d, 0, "");
            end else if (r < 6) begin
                cyc(tk, 1, 4'h4, m_cnt + $urandom_range(1, 3), 0, "");
            end else if (r < 30) begin
                cyc(tk, 0, 4'($urandom_range(0, 3) << 2), 0, 1, "R1 random read");
            end else begin
                cyc(tk, 0, 4'h0, 0, 0, "");
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule